// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a TLB miss by walking the in-memory translation tables. The TLB presents the missing virtual address and the security state of the request. The walker uses the base registers and control field of the requester's own world to pick one of two table bases. It then reads a first-level descriptor over a single-outstanding memory read port. If that descriptor points to a coarse second-level table, it reads a second-level descriptor as well. It returns the physical base of the mapped region, its size and a fault indication to the TLB.

Each world has a walk-disable bit for each of its two bases. If the selected base is disabled, the walk ends at once with a section translation fault and no memory read is made. Every descriptor read carries the requester's secure or non-secure state. Every read also carries the region attributes held in the low five bits of the selected base register. The register values are plain inputs and must stay stable while a walk is in progress.

The miss input is a valid/ready channel. The walker raises `miss_ready` only when idle. A miss is taken on a cycle where `miss_valid` and `miss_ready` are both high. The read request is also valid/ready. Once `rd_valid` is raised, it stays high with unchanged address, security tag and attributes until `rd_ready` is seen. The read data comes back later as a single-cycle `rsp_valid` beat. There is no back-pressure on responses or on results.

Top module: `tt_walker`

## Requirements
- R1: `miss_ready` is high exactly when the walker is idle. A miss is taken only on a cycle where `miss_valid` and `miss_ready` are both high. While a walk is in progress, neither `miss_ready` nor a second walk occurs.
- R2: The selection control `split` is 3 bits wide. A value of 0 always selects base 0. For a nonzero value n, a virtual address with any set bit among its top n bits selects base 1; otherwise base 0 is selected. The base registers and `split` come from the secure set when `miss_secure`=1 and from the non-secure set otherwise.
- R3: The first-level read address is formed as follows. With base 0 it is base0 bits [31:14-n], then VA bits [31-n:20], then two zero bits. With base 1 it is base1 bits [31:14], then VA bits [31:20], then two zero bits.
- R4: If the selected base has its world's disable bit set (`nowalk0` for base 0, `nowalk1` for base 1), no read is issued. `done` rises in the cycle after acceptance, with `fault`=1 and `fault_page`=0.
- R5: `rd_valid` stays high, with `rd_addr`, `rd_secure` and `rd_attr` stable, until `rd_ready` is high. After a handshake, no new request is raised until `rsp_valid` has delivered that read's data.
- R6: Every read has `rd_secure` equal to the `miss_secure` of the walk. `rd_attr` equals bits [4:0] of the selected base register.
- R7: First-level descriptor bits [1:0] are decoded as follows. 10 is a 1 MB section: `pa_base` is descriptor[31:20] followed by zeros, and `page_size`=00. 01 is a coarse table. 00 or 11 is a section translation fault (`fault_page`=0), and the remaining descriptor bits have no effect.
- R8: For a coarse table, exactly one second-level read is made, at descriptor[31:10], then VA[19:12], then 00. Its bits [1:0] are decoded as follows. 01 is a 64 KB large page: `pa_base` is descriptor[31:16] followed by zeros, and `page_size`=01. 10 or 11 is a 4 KB small page: `pa_base` is descriptor[31:12] followed by zeros, and `page_size`=10. 00 is a page translation fault (`fault_page`=1).
- R9: `done` is a one-cycle pulse. On a fault, `pa_base` is 0 and `page_size` is 00. On success, `fault` and `fault_page` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | TLB miss request valid |
| miss_ready | output | 1 | Walker idle, can take a miss |
| miss_va | input | 32 | Missing virtual address |
| miss_secure | input | 1 | Requester is in the secure world |
| sec_base0 | input | 32 | Secure world table base 0 (bits [4:0] are attributes) |
| sec_base1 | input | 32 | Secure world table base 1 (bits [4:0] are attributes) |
| sec_split | input | 3 | Secure world base selection control |
| sec_nowalk0 | input | 1 | Secure world walk disable for base 0 |
| sec_nowalk1 | input | 1 | Secure world walk disable for base 1 |
| nsec_base0 | input | 32 | Non-secure world table base 0 |
| nsec_base1 | input | 32 | Non-secure world table base 1 |
| nsec_split | input | 3 | Non-secure world base selection control |
| nsec_nowalk0 | input | 1 | Non-secure world walk disable for base 0 |
| nsec_nowalk1 | input | 1 | Non-secure world walk disable for base 1 |
| rd_valid | output | 1 | Descriptor read request valid |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 32 | Descriptor byte address |
| rd_secure | output | 1 | Read carries secure access rights |
| rd_attr | output | 5 | Region attributes for the read |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Descriptor read data |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | Walk ended in a translation fault |
| fault_page | output | 1 | Fault type: 0 section, 1 page |
| pa_base | output | 32 | Physical base of the mapped region |
| page_size | output | 2 | 00 section, 01 large page, 10 small page |

## Verification
The assertions assume three things about the inputs. The per-world base, split and disable inputs stay constant from acceptance until `done`. `rsp_valid` arrives only once per accepted read and never before that read's handshake. `rd_ready` has no effect when `rd_valid` is low. The stimulus follows these rules: it changes the register inputs only while the walker is idle, and it drives `rsp_valid` from a responder that answers only after it has granted `rd_ready`, after a random delay of zero to two cycles. Random stall patterns on `rd_ready` exercise the request-hold rule.

// File: rtl/tt_walker_pkg.sv
package tt_walker_pkg;
  localparam int DW       = 32;           // address and descriptor width
  localparam int SPLIT_W  = 3;            // base selection control width
  localparam int ATTR_W   = 5;            // region attribute field width
  localparam int SECT_SH  = 20;           // 1 MB section shift
  localparam int LARGE_SH = 16;           // 64 KB page shift
  localparam int SMALL_SH = 12;           // 4 KB page shift
  localparam int L1_IDX_W = DW - SECT_SH; // first-level index bits
  localparam int L1_ALN   = L1_IDX_W + 2; // first-level table alignment
  localparam int L2_IDX_W = SECT_SH - SMALL_SH;
  localparam int L2_ALN   = L2_IDX_W + 2;

  typedef enum logic [2:0] {
    DK_FAULT, DK_SECTION, DK_TABLE, DK_LARGE, DK_SMALL
  } dkind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } wstate_e;

  localparam logic [1:0] SZ_SECTION = 2'b00;
  localparam logic [1:0] SZ_LARGE   = 2'b01;
  localparam logic [1:0] SZ_SMALL   = 2'b10;
endpackage

// File: rtl/tt_walk_root.sv
module tt_walk_root
  import tt_walker_pkg::*;
(
  input  logic [DW-1:0]      va,
  input  logic [DW-1:0]      base0,
  input  logic [DW-1:0]      base1,
  input  logic [SPLIT_W-1:0] split,
  input  logic               nowalk0,
  input  logic               nowalk1,
  output logic               use_b1,
  output logic               blocked,
  output logic [DW-1:0]      l1_addr,
  output logic [ATTR_W-1:0]  attr
);
  logic [DW-1:0] mask0;
  logic [DW-1:0] idx0;
  logic [DW-1:0] addr0;
  logic [DW-1:0] addr1;

  always_comb begin
    use_b1 = 1'b0;
    if (split != '0)
      use_b1 = (va >> (DW - int'(split))) != '0;
    // base 0 table shrinks as the split grows
    mask0 = {DW{1'b1}} << (L1_ALN - int'(split));
    idx0  = (va >> SECT_SH) & ({DW{1'b1}} >> (DW - L1_IDX_W + int'(split)));
    addr0 = (base0 & mask0) | (idx0 << 2);
    addr1 = {base1[DW-1:L1_ALN], va[DW-1:SECT_SH], 2'b00};
    l1_addr = use_b1 ? addr1 : addr0;
    blocked = use_b1 ? nowalk1 : nowalk0;
    attr    = use_b1 ? base1[ATTR_W-1:0] : base0[ATTR_W-1:0];
  end
endmodule

// File: rtl/tt_walk_decode.sv
module tt_walk_decode
  import tt_walker_pkg::*;
(
  input  logic [DW-1:0] desc,
  input  logic          second,
  input  logic [DW-1:0] va,
  output dkind_e        kind,
  output logic [DW-1:0] pa,
  output logic [DW-1:0] next_addr
);
  always_comb begin
    kind      = DK_FAULT;
    pa        = '0;
    next_addr = {desc[DW-1:L2_ALN], va[SECT_SH-1:SMALL_SH], 2'b00};
    if (!second) begin
      unique case (desc[1:0])
        2'b10: begin
          kind = DK_SECTION;
          pa   = {desc[DW-1:SECT_SH], {SECT_SH{1'b0}}};
        end
        2'b01:   kind = DK_TABLE;
        default: kind = DK_FAULT;   // unmapped, or removed fine table
      endcase
    end else begin
      unique case (desc[1:0])
        2'b00: kind = DK_FAULT;
        2'b01: begin
          kind = DK_LARGE;
          pa   = {desc[DW-1:LARGE_SH], {LARGE_SH{1'b0}}};
        end
        default: begin
          kind = DK_SMALL;
          pa   = {desc[DW-1:SMALL_SH], {SMALL_SH{1'b0}}};
        end
      endcase
    end
  end
endmodule

// File: rtl/tt_walker.sv
module tt_walker
  import tt_walker_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [DW-1:0]      miss_va,
  input  logic               miss_secure,
  input  logic [DW-1:0]      sec_base0,
  input  logic [DW-1:0]      sec_base1,
  input  logic [SPLIT_W-1:0] sec_split,
  input  logic               sec_nowalk0,
  input  logic               sec_nowalk1,
  input  logic [DW-1:0]      nsec_base0,
  input  logic [DW-1:0]      nsec_base1,
  input  logic [SPLIT_W-1:0] nsec_split,
  input  logic               nsec_nowalk0,
  input  logic               nsec_nowalk1,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [DW-1:0]      rd_addr,
  output logic               rd_secure,
  output logic [ATTR_W-1:0]  rd_attr,
  input  logic               rsp_valid,
  input  logic [DW-1:0]      rsp_data,
  output logic               done,
  output logic               fault,
  output logic               fault_page,
  output logic [DW-1:0]      pa_base,
  output logic [1:0]         page_size
);
  wstate_e             state;
  logic [DW-1:0]       va_q;
  logic                sec_q;
  logic [ATTR_W-1:0]   attr_q;
  logic [DW-1:0]       addr_q;

  logic [DW-1:0]       w_base0, w_base1;
  logic [SPLIT_W-1:0]  w_split;
  logic                w_nw0, w_nw1;
  logic                use_b1, blocked;
  logic [DW-1:0]       l1_addr;
  logic [ATTR_W-1:0]   attr;

  dkind_e              kind;
  logic [DW-1:0]       dec_pa, dec_next;
  logic                in_l2;

  // world-banked register selection
  always_comb begin
    w_base0 = miss_secure ? sec_base0   : nsec_base0;
    w_base1 = miss_secure ? sec_base1   : nsec_base1;
    w_split = miss_secure ? sec_split   : nsec_split;
    w_nw0   = miss_secure ? sec_nowalk0 : nsec_nowalk0;
    w_nw1   = miss_secure ? sec_nowalk1 : nsec_nowalk1;
  end

  tt_walk_root root_i (
    .va(miss_va), .base0(w_base0), .base1(w_base1), .split(w_split),
    .nowalk0(w_nw0), .nowalk1(w_nw1), .use_b1(use_b1), .blocked(blocked),
    .l1_addr(l1_addr), .attr(attr)
  );

  assign in_l2 = (state == ST_L2_WAIT);

  tt_walk_decode dec_i (
    .desc(rsp_data), .second(in_l2), .va(va_q),
    .kind(kind), .pa(dec_pa), .next_addr(dec_next)
  );

  assign miss_ready = (state == ST_IDLE);
  assign rd_valid   = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign rd_addr    = addr_q;
  assign rd_secure  = sec_q;
  assign rd_attr    = attr_q;
  assign done       = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      va_q       <= '0;
      sec_q      <= 1'b0;
      attr_q     <= '0;
      addr_q     <= '0;
      fault      <= 1'b0;
      fault_page <= 1'b0;
      pa_base    <= '0;
      page_size  <= SZ_SECTION;
    end else begin
      unique case (state)
        ST_IDLE: if (miss_valid) begin
          va_q   <= miss_va;
          sec_q  <= miss_secure;
          attr_q <= attr;
          addr_q <= l1_addr;
          if (blocked) begin
            fault      <= 1'b1;
            fault_page <= 1'b0;
            pa_base    <= '0;
            page_size  <= SZ_SECTION;
            state      <= ST_DONE;
          end else begin
            state <= ST_L1_REQ;
          end
        end
        ST_L1_REQ: if (rd_ready) state <= ST_L1_WAIT;
        ST_L2_REQ: if (rd_ready) state <= ST_L2_WAIT;
        ST_L1_WAIT, ST_L2_WAIT: if (rsp_valid) begin
          unique case (kind)
            DK_TABLE: begin
              addr_q <= dec_next;
              state  <= ST_L2_REQ;
            end
            DK_FAULT: begin
              fault      <= 1'b1;
              fault_page <= in_l2;
              pa_base    <= '0;
              page_size  <= SZ_SECTION;
              state      <= ST_DONE;
            end
            default: begin
              fault      <= 1'b0;
              fault_page <= 1'b0;
              pa_base    <= dec_pa;
              page_size  <= (kind == DK_LARGE) ? SZ_LARGE :
                            (kind == DK_SMALL) ? SZ_SMALL : SZ_SECTION;
              state      <= ST_DONE;
            end
          endcase
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tt_walker_chk.sv
module tt_walker_chk
  import tt_walker_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               miss_valid,
  input logic               miss_ready,
  input logic [DW-1:0]      miss_va,
  input logic               miss_secure,
  input logic [DW-1:0]      sec_base0,
  input logic [DW-1:0]      sec_base1,
  input logic [SPLIT_W-1:0] sec_split,
  input logic               sec_nowalk0,
  input logic               sec_nowalk1,
  input logic [DW-1:0]      nsec_base0,
  input logic [DW-1:0]      nsec_base1,
  input logic [SPLIT_W-1:0] nsec_split,
  input logic               nsec_nowalk0,
  input logic               nsec_nowalk1,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic [DW-1:0]      rd_addr,
  input logic               rd_secure,
  input logic [ATTR_W-1:0]  rd_attr,
  input logic               rsp_valid,
  input logic [DW-1:0]      rsp_data,
  input logic               done,
  input logic               fault,
  input logic               fault_page,
  input logic [DW-1:0]      pa_base,
  input logic [1:0]         page_size
);
  logic [SPLIT_W-1:0] c_split;
  logic               c_top, c_off, take;
  logic               sec_seen;

  always_comb begin
    c_split = miss_secure ? sec_split : nsec_split;
    c_top   = 1'b0;
    for (int b = 0; b < (1 << SPLIT_W); b++)
      if (b < int'(c_split) && miss_va[DW-1-b]) c_top = 1'b1;
    c_off = c_top ? (miss_secure ? sec_nowalk1 : nsec_nowalk1)
                  : (miss_secure ? sec_nowalk0 : nsec_nowalk0);
    take  = miss_valid && miss_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sec_seen <= 1'b0;
    else if (take) sec_seen <= miss_secure;
  end

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || done) |-> !miss_ready);

  a_r4_blocked_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (take && c_off) |=> (done && fault && !fault_page && !rd_valid));

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)
                                 && $stable(rd_attr) && $stable(rd_secure)));

  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_valid);

  a_r6_secure_tag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_secure == sec_seen));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (pa_base == '0 && page_size == 2'b00));
endmodule

bind tt_walker tt_walker_chk chk_i (.*);

// File: tb/tt_walker_tb_top.sv
module tt_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_va = '0;
  logic        miss_secure = 1'b0;
  logic [31:0] sec_base0 = '0, sec_base1 = '0, nsec_base0 = '0, nsec_base1 = '0;
  logic [2:0]  sec_split = '0, nsec_split = '0;
  logic        sec_nowalk0 = 0, sec_nowalk1 = 0, nsec_nowalk0 = 0, nsec_nowalk1 = 0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rd_secure;
  logic [4:0]  rd_attr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        done, fault, fault_page;
  logic [31:0] pa_base;
  logic [1:0]  page_size;

  int total = 0;
  int bad = 0;
  int force1 = -1;   // forced first-level type, -1 none
  int force2 = -1;   // forced second-level type, -1 none

  // expected results
  int          e_reads;
  logic [31:0] e_a1, e_a2, e_pa;
  logic        e_fault, e_fpage;
  logic [1:0]  e_size;
  logic [4:0]  e_attr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_walker dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a, input logic s,
                                           input int lvl);
    logic [31:0] h;
    h = a * 32'h9E37_79B1;
    h = h ^ (h >> 13) ^ (s ? 32'hC3A5_0000 : 32'h0);
    if (lvl == 0 && force1 >= 0) h[1:0] = 2'(force1);
    if (lvl == 1 && force2 >= 0) h[1:0] = 2'(force2);
    return h;
  endfunction

  task automatic model(input logic [31:0] va, input logic s);
    logic [31:0] b0, b1, d1, d2;
    int n;
    logic u1, off;
    b0  = s ? sec_base0 : nsec_base0;
    b1  = s ? sec_base1 : nsec_base1;
    n   = int'(s ? sec_split : nsec_split);
    u1  = (n != 0) && ((va >> (32 - n)) != 0);
    off = u1 ? (s ? sec_nowalk1 : nsec_nowalk1) : (s ? sec_nowalk0 : nsec_nowalk0);
    e_attr = u1 ? b1[4:0] : b0[4:0];
    e_a1 = u1 ? {b1[31:14], va[31:20], 2'b00}
              : ((b0 >> (14 - n)) << (14 - n)) | (((va << n) >> (n + 20)) << 2);
    e_a2 = '0; e_pa = '0; e_size = 2'b00; e_fault = 1'b1; e_fpage = 1'b0;
    if (off) begin
      e_reads = 0;
      return;
    end
    e_reads = 1;
    d1 = mem_word(e_a1, s, 0);
    if (d1[1:0] == 2'b10) begin
      e_fault = 1'b0; e_pa = d1 & 32'hFFF0_0000;
    end else if (d1[1:0] == 2'b01) begin
      e_reads = 2;
      e_a2 = {d1[31:10], va[19:12], 2'b00};
      d2 = mem_word(e_a2, s, 1);
      if (d2[1:0] == 2'b00) e_fpage = 1'b1;
      else if (d2[1:0] == 2'b01) begin
        e_fault = 1'b0; e_pa = d2 & 32'hFFFF_0000; e_size = 2'b01;
      end else begin
        e_fault = 1'b0; e_pa = d2 & 32'hFFFF_F000; e_size = 2'b10;
      end
    end
  endtask

  task automatic run_walk(input logic [31:0] va, input logic s);
    int reads = 0, cyc = 0, ph = 0, dly = 0;
    logic [31:0] held;
    model(va, s);
    @(negedge clk);
    chk(miss_ready === 1'b1, "R1 idle ready", 32'(miss_ready), 1);
    miss_valid = 1'b1; miss_va = va; miss_secure = s;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(miss_ready === 1'b0, "R1 busy not ready", 32'(miss_ready), 0);
    held = '0;
    while (cyc < 40) begin
      if (done === 1'b1) break;
      if (ph == 0) begin
        rd_ready = 1'b0;
        if (rd_valid === 1'b1) begin
          chk(rd_addr === ((reads == 0) ? e_a1 : e_a2),
              (reads == 0) ? "R3 l1 addr" : "R8 l2 addr",
              rd_addr, (reads == 0) ? e_a1 : e_a2);
          chk(rd_secure === s && rd_attr === e_attr, "R6 tag attr",
              {26'b0, rd_secure, rd_attr}, {26'b0, s, e_attr});
          if (cyc > 0 && held != '0)
            chk(rd_addr === held, "R5 hold", rd_addr, held);
          held = rd_addr;
          if ($urandom % 2 == 1) begin
            rd_ready = 1'b1; ph = 1; dly = int'($urandom % 3);
          end
        end
      end else begin
        rd_ready = 1'b0;
        chk(rd_valid === 1'b0, "R5 one outstanding", 32'(rd_valid), 0);
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = mem_word(held, s, reads);
          reads++; ph = 0; held = '0;
        end else dly--;
      end
      @(negedge clk);
      rsp_valid = 1'b0;
      cyc++;
    end
    rd_ready = 1'b0;
    chk(done === 1'b1, "R9 done seen", 32'(done), 1);
    chk(reads == e_reads, "R4 R7 R8 read count", 32'(reads), 32'(e_reads));
    if (e_reads == 0)
      chk(cyc == 0, "R4 immediate done", 32'(cyc), 0);
    chk(fault === e_fault && fault_page === e_fpage,
        e_fpage ? "R8 page fault" : "R7 fault flags",
        {30'b0, fault, fault_page}, {30'b0, e_fault, e_fpage});
    chk(pa_base === e_pa && page_size === e_size, "R9 R7 R8 result",
        pa_base ^ {30'b0, page_size}, e_pa ^ {30'b0, e_size});
    @(negedge clk);
    chk(done === 1'b0, "R9 pulse", 32'(done), 0);
  endtask

  task automatic rand_regs();
    sec_base0 = $urandom; sec_base1 = $urandom;
    nsec_base0 = $urandom; nsec_base1 = $urandom;
    sec_split = 3'($urandom); nsec_split = 3'($urandom);
    sec_nowalk0 = ($urandom % 6 == 0); sec_nowalk1 = ($urandom % 6 == 0);
    nsec_nowalk0 = ($urandom % 6 == 0); nsec_nowalk1 = ($urandom % 6 == 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready === 1'b1 && rd_valid === 1'b0 && done === 1'b0,
        "R1 reset state", {29'b0, miss_ready, rd_valid, done}, 32'b100);

    // R4: secure base 0 disabled, non-secure base 1 disabled
    sec_base0 = 32'h1234_5000; sec_base1 = 32'h8000_4013; sec_split = 3'd1;
    nsec_base0 = 32'h0040_000A; nsec_base1 = 32'h00C0_0007; nsec_split = 3'd2;
    sec_nowalk0 = 1; run_walk(32'h0012_3456, 1'b1);
    sec_nowalk0 = 0; nsec_nowalk1 = 1; run_walk(32'h4001_0000, 1'b0);
    // R2: same VA walks normally in the other world
    run_walk(32'h4001_0000, 1'b1);
    nsec_nowalk1 = 0;
    // R2: split 0 keeps base 0 for a top address; split 7 boundary
    nsec_split = 3'd0; run_walk(32'hFFF0_0000, 1'b0);
    nsec_split = 3'd7; run_walk(32'h01FF_F000, 1'b0);
    run_walk(32'h0200_0000, 1'b0);
    // R7: section, removed fine type, unmapped
    force1 = 2; run_walk(32'h0350_0000, 1'b1);
    force1 = 3; run_walk(32'h0350_0000, 1'b1);
    force1 = 0; run_walk(32'h0210_0000, 1'b0);
    // R8: large, small (10 and 11), page fault
    force1 = 1;
    force2 = 1; run_walk(32'h0123_4567, 1'b0);
    force2 = 2; run_walk(32'h0123_4567, 1'b1);
    force2 = 3; run_walk(32'h00AB_C000, 1'b0);
    force2 = 0; run_walk(32'h00AB_C000, 1'b1);
    force1 = -1; force2 = -1;

    for (int i = 0; i < N_RANDOM; i++) begin
      rand_regs();
      if (i % 3 == 0) force1 = 1; else force1 = -1;
      run_walk($urandom, 1'($urandom));
    end
    force1 = -1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule